// File: doc/BRIEF.md
# Motion Pulse Qualifier

This block sits after a synchronized window-comparator output in a passive-infrared motion path. It decides whether a disturbance lasted long enough to be real motion, turns each accepted disturbance into one clean clock-wide event, and turns those events into a trigger for the downstream output-duration timer. A mode input selects whether one accepted event is enough, or whether two must arrive close together. The same events also drive a retriggerable one-shot that lights a motion LED in either mode.

All timing is counted in ticks of one slow enable, `tick_en`, which is one clock wide and repeats at the mains or oscillator rate (30, 50 or 60 Hz). The input `cmp_active` is sampled only on tick cycles. Window lengths are parameters in ticks: `FILT_TICKS` = 4 for the persistence filter, `LED_TICKS` = 60 for the LED (about 1 s at 60 Hz), and `PAIR_TICKS` = 307 for the pairing window (about 5.1 s at 60 Hz). At other tick rates the same counts scale in time.

There are three state machines. The filter has `F_IDLE`, `F_COUNT` and `F_HELD`. The move from idle to count happens on an active tick. Count goes back to idle on an inactive tick. Count moves to held on the qualifying tick, and that move emits the event. Held goes back to idle on an inactive tick. The pairer has `P_EMPTY` and `P_ARMED`. Empty moves to armed on a first event in dual mode. Armed goes back to empty in three cases: on a second event (a pair), on window expiry, or when single mode is selected. The LED one-shot has `L_DARK` and `L_LIT`. Dark moves to lit on an event. Lit reloads on an event and goes back to dark when its count runs out.

Top module: `motion_qualifier`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the filter count, the pairing state and the LED timer. In the cycle after it, `qual_pulse`, `trig_pulse` and `led_on` are 0. A partly counted disturbance or an armed first event from before the reset has no effect afterwards.
- R2: `qual_pulse` is high for exactly one clock, in the cycle after the clock on which the `FILT_TICKS`-th consecutive tick samples `cmp_active` = 1. A run of fewer consecutive active ticks gives no pulse.
- R3: A continuous active run gives one pulse only, however long it lasts. A new pulse needs at least one tick that samples `cmp_active` = 0, followed by a fresh run of `FILT_TICKS` active ticks.
- R4: `cmp_active` is ignored on clocks where `tick_en` = 0. Holding it high with no tick produces no pulse.
- R5: With `dual_mode` = 0 (single-pulse mode), every `qual_pulse` is followed in the next clock by a one-clock `trig_pulse`.
- R6: With `dual_mode` = 1 (dual-pulse mode), a first `qual_pulse` arms the pairer and gives no trigger. A second `qual_pulse` whose qualifying tick is no later than tick `PAIR_TICKS`-1 after the first qualifying tick gives a one-clock `trig_pulse` in the next clock, and the pairer disarms.
- R7: In dual-pulse mode, the armed first event is discarded on tick `PAIR_TICKS` after it. A later `qual_pulse` then arms afresh and gives no trigger. Selecting single mode also discards it.
- R8: `led_on` rises in the clock after any `qual_pulse`, in either mode. It stays high through `LED_TICKS`-1 further ticks and falls on tick `LED_TICKS`. A new `qual_pulse` while lit restarts the full count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-clock enable at the slow timing rate |
| cmp_active | input | 1 | Synchronized window-comparator active level |
| dual_mode | input | 1 | 0 = single-pulse trigger, 1 = dual-pulse trigger |
| qual_pulse | output | 1 | One-clock event per qualified disturbance |
| trig_pulse | output | 1 | One-clock trigger for the output-duration timer |
| led_on | output | 1 | Motion LED enable from the retriggerable one-shot |

## Verification
The filter is driven with active runs of three, four, five and twelve ticks. These separate too-short bursts from just-qualifying ones, and show that a long burst gives only one event. The same runs are repeated in both modes, so that a direct trigger can be told apart from an arm and a pair. The pairing window is probed with gaps that place the second qualifying tick at tick 306 and at tick 307 after the first, which pins down the expiry edge and the fresh arming that follows it. The LED is timed from a single event and from a second event inside the lit period, and it is also checked in dual mode without a trigger.

// File: rtl/mq_pkg.sv
package mq_pkg;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_COUNT = 2'd1,
        F_HELD  = 2'd2
    } filt_state_t;

    typedef enum logic {
        P_EMPTY = 1'b0,
        P_ARMED = 1'b1
    } pair_state_t;

    typedef enum logic {
        L_DARK = 1'b0,
        L_LIT  = 1'b1
    } led_state_t;

endpackage

// File: rtl/mq_filter.sv
module mq_filter
    import mq_pkg::*;
#(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic cmp_active,
    output logic qual_pulse
);

    localparam int CW = $clog2(FILT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

    filt_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          fire;

    // next-state logic: only tick cycles move the machine
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (tick_en) begin
            unique case (state_q)
                F_IDLE: begin
                    if (cmp_active) begin
                        if (FILT_TICKS == 1) begin
                            fire    = 1'b1;
                            state_d = F_HELD;
                        end else begin
                            cnt_d   = CW'(1);
                            state_d = F_COUNT;
                        end
                    end
                end
                F_COUNT: begin
                    if (!cmp_active) begin
                        cnt_d   = '0;
                        state_d = F_IDLE;
                    end else if (cnt_q == LAST) begin
                        cnt_d   = '0;
                        fire    = 1'b1;
                        state_d = F_HELD;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                F_HELD: begin
                    if (!cmp_active) begin
                        state_d = F_IDLE;
                    end
                end
                default: begin
                    cnt_d   = '0;
                    state_d = F_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= F_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            qual_pulse <= 1'b0;
        end else begin
            qual_pulse <= fire;
        end
    end

    // R2: an event lasts one clock
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
        qual_pulse |=> !qual_pulse);

    // R2: an event only follows a tick clock
    a_r2_after_tick: assert property (@(posedge clk) disable iff (rst)
        qual_pulse |-> $past(tick_en));

    // R3: a held run gives no further event
    a_r3_held_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == F_HELD && cmp_active) |=> !qual_pulse);

    // R4: without a tick the filter does not move
    a_r4_no_tick_stable: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(state_q) && $stable(cnt_q)));

endmodule

// File: rtl/mq_pairer.sv
module mq_pairer
    import mq_pkg::*;
#(
    parameter int PAIR_TICKS = 307
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic dual_mode,
    input  logic qual,
    output logic trig_pulse
);

    localparam int PW = $clog2(PAIR_TICKS + 1);
    localparam logic [PW-1:0] LAST = PW'(PAIR_TICKS - 1);

    pair_state_t   state_q, state_d;
    logic [PW-1:0] win_q, win_d;
    logic          hit;

    // next-state logic; an event outranks a coincident tick
    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        hit     = 1'b0;
        if (!dual_mode) begin
            state_d = P_EMPTY;
            win_d   = '0;
            hit     = qual;
        end else begin
            unique case (state_q)
                P_EMPTY: begin
                    if (qual) begin
                        state_d = P_ARMED;
                        win_d   = '0;
                    end
                end
                P_ARMED: begin
                    if (qual) begin
                        hit     = 1'b1;
                        state_d = P_EMPTY;
                        win_d   = '0;
                    end else if (tick_en) begin
                        if (win_q == LAST) begin
                            state_d = P_EMPTY;
                            win_d   = '0;
                        end else begin
                            win_d = win_q + PW'(1);
                        end
                    end
                end
                default: begin
                    state_d = P_EMPTY;
                    win_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= P_EMPTY;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_pulse <= 1'b0;
        end else begin
            trig_pulse <= hit;
        end
    end

    // R5: single mode passes every event on
    a_r5_single_follows: assert property (@(posedge clk) disable iff (rst)
        (!dual_mode && qual) |=> trig_pulse);

    // R6: a trigger is always caused by an event
    a_r6_trig_from_qual: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(qual));

    // R6: the first event of a pair never triggers
    a_r6_arm_no_trig: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && state_q == P_EMPTY && qual) |=> (!trig_pulse && state_q == P_ARMED));

    // R7: the window closes on its last tick
    a_r7_expire: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && state_q == P_ARMED && !qual && tick_en && win_q == LAST)
        |=> state_q == P_EMPTY);

endmodule

// File: rtl/mq_led.sv
module mq_led
    import mq_pkg::*;
#(
    parameter int LED_TICKS = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic qual,
    output logic led_on
);

    localparam int LW = $clog2(LED_TICKS + 1);
    localparam logic [LW-1:0] FULL = LW'(LED_TICKS);

    led_state_t    state_q, state_d;
    logic [LW-1:0] cnt_q, cnt_d;

    // next-state logic; an event reloads before a tick counts
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            L_DARK: begin
                if (qual) begin
                    state_d = L_LIT;
                    cnt_d   = FULL;
                end
            end
            L_LIT: begin
                if (qual) begin
                    cnt_d = FULL;
                end else if (tick_en) begin
                    if (cnt_q == LW'(1)) begin
                        state_d = L_DARK;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - LW'(1);
                    end
                end
            end
            default: begin
                state_d = L_DARK;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= L_DARK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output decode
    always_comb begin
        led_on = (state_q == L_LIT);
    end

    // R8: an event always lights the LED
    a_r8_lit_after_qual: assert property (@(posedge clk) disable iff (rst)
        qual |=> led_on);

    // R8: the LED only goes dark on a tick
    a_r8_dark_on_tick: assert property (@(posedge clk) disable iff (rst)
        (led_on && !qual && !tick_en) |=> led_on);

endmodule

// File: rtl/motion_qualifier.sv
module motion_qualifier #(
    parameter int FILT_TICKS = 4,
    parameter int LED_TICKS  = 60,
    parameter int PAIR_TICKS = 307
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic cmp_active,
    input  logic dual_mode,
    output logic qual_pulse,
    output logic trig_pulse,
    output logic led_on
);

    logic qual_w;

    mq_filter #(.FILT_TICKS(FILT_TICKS)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .cmp_active (cmp_active),
        .qual_pulse (qual_w)
    );

    mq_pairer #(.PAIR_TICKS(PAIR_TICKS)) u_pairer (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .dual_mode  (dual_mode),
        .qual       (qual_w),
        .trig_pulse (trig_pulse)
    );

    mq_led #(.LED_TICKS(LED_TICKS)) u_led (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .qual    (qual_w),
        .led_on  (led_on)
    );

    assign qual_pulse = qual_w;

    // R1: reset clears every output on the next clock
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!qual_pulse && !trig_pulse && !led_on));

endmodule

// File: tb/motion_qualifier_test.sv
module motion_qualifier_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic cmp_active = 1'b0;
    logic dual_mode = 1'b0;
    logic qual_pulse, trig_pulse, led_on;

    int checks = 0;
    int errors = 0;
    int qn = 0;
    int tn = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic dual;
        int   act;
        int   idle;
        int   exp_q;
        int   exp_t;
    } row_t;

    localparam int NROWS = 6;
    localparam row_t ROWS [NROWS] = '{
        '{1'b0,  3, 2, 0, 0},   // R2 short run rejected
        '{1'b0,  4, 2, 1, 1},   // R2 R5 just qualifies, direct trigger
        '{1'b0, 12, 2, 1, 1},   // R3 long run, one event
        '{1'b1,  4, 2, 1, 0},   // R6 first event arms
        '{1'b1,  5, 2, 1, 1},   // R6 second event pairs
        '{1'b1,  4, 2, 1, 0}    // R6 arms again
    };

    always #10 clk = ~clk;

    motion_qualifier uut (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .cmp_active (cmp_active),
        .dual_mode  (dual_mode),
        .qual_pulse (qual_pulse),
        .trig_pulse (trig_pulse),
        .led_on     (led_on)
    );

    // pulse monitor: counts high cycles, so a stretched pulse counts twice
    always @(negedge clk) begin
        if (qual_pulse) qn++;
        if (trig_pulse) tn++;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input logic a);
        @(negedge clk);
        cmp_active = a;
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input logic a, input int n);
        for (int k = 0; k < n; k++) tick(a);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int q0, t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset qual", int'(qual_pulse), 0);
        check("R1 reset trig", int'(trig_pulse), 0);
        check("R1 reset led", int'(led_on), 0);

        for (int i = 0; i < NROWS; i++) begin
            dual_mode = ROWS[i].dual;
            q0 = qn;
            t0 = tn;
            ticks(1'b0, 2);
            ticks(1'b1, ROWS[i].act);
            ticks(1'b0, ROWS[i].idle);
            check($sformatf("R2 R3 R5 R6 row %0d qual", i), qn - q0, ROWS[i].exp_q);
            check($sformatf("R5 R6 row %0d trig", i), tn - t0, ROWS[i].exp_t);
        end

        // R1: reset drops the armed event and the lit LED
        do_reset();
        check("R1 led after reset", int'(led_on), 0);
        check("R1 trig after reset", int'(trig_pulse), 0);
        q0 = qn; t0 = tn;
        ticks(1'b1, 4); tick(1'b0);
        check("R1 armed cleared qual", qn - q0, 1);
        check("R1 armed cleared trig", tn - t0, 0);

        // R1: reset clears a partial count
        do_reset();
        ticks(1'b1, 3);
        do_reset();
        q0 = qn;
        tick(1'b1); tick(1'b0);
        check("R1 partial count cleared", qn - q0, 0);

        // R4: no tick, no sampling
        do_reset();
        q0 = qn;
        @(negedge clk);
        cmp_active = 1'b1;
        repeat (40) @(negedge clk);
        cmp_active = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 held without tick", qn - q0, 0);

        // R6 window edge: second qualifying tick is tick 306
        do_reset();
        dual_mode = 1'b1;
        t0 = tn;
        ticks(1'b1, 4);
        ticks(1'b0, 302);
        ticks(1'b1, 4);
        tick(1'b0);
        check("R6 pair at last window tick", tn - t0, 1);

        // R7 window edge: second qualifying tick is tick 307
        do_reset();
        t0 = tn;
        ticks(1'b1, 4);
        ticks(1'b0, 303);
        ticks(1'b1, 4);
        tick(1'b0);
        check("R7 expired first discarded", tn - t0, 0);
        t0 = tn;
        ticks(1'b1, 4);
        tick(1'b0);
        check("R7 late event re-armed", tn - t0, 1);

        // R7: switching to single mode discards the armed event
        do_reset();
        ticks(1'b1, 4); tick(1'b0);
        dual_mode = 1'b0;
        @(negedge clk);
        dual_mode = 1'b1;
        t0 = tn;
        ticks(1'b1, 4); tick(1'b0);
        check("R7 mode change discards", tn - t0, 0);

        // R8: LED timing from one event
        do_reset();
        dual_mode = 1'b0;
        ticks(1'b1, 4);
        check("R8 led lit", int'(led_on), 1);
        ticks(1'b0, 59);
        check("R8 led tick 59", int'(led_on), 1);
        tick(1'b0);
        check("R8 led tick 60", int'(led_on), 0);

        // R8: LED in dual mode without a trigger
        do_reset();
        dual_mode = 1'b1;
        t0 = tn;
        ticks(1'b1, 4);
        check("R8 led dual mode", int'(led_on), 1);
        check("R8 no trig dual mode", tn - t0, 0);

        // R8: retrigger restarts the count
        do_reset();
        dual_mode = 1'b0;
        ticks(1'b1, 4);
        tick(1'b0);
        ticks(1'b1, 4);
        ticks(1'b0, 59);
        check("R8 retrigger held", int'(led_on), 1);
        tick(1'b0);
        check("R8 retrigger expiry", int'(led_on), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule